// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block is the digital back end of a two-channel 8-bit sampling converter. On every rising clock edge it accepts one raw conversion code per channel. Each code arrives in offset binary. The block carries the pair through a fixed-latency pipeline and latches it into an output holding register. The held word is then presented in the coding chosen by a select pin. Each channel has its own data bus, its own drive-enable signal and its own valid flag, and the bus is tri-stated when the enable is low.

Two power inputs are handled. A sleep input stops new samples from entering the pipeline. A power-down input does the same and also freezes the held output words. After either input is released, a wake-up interval of a parameterised number of cycles passes before sampling resumes. The valid flags return only once the pipeline has refilled with fresh samples. Both channels share one pipeline control, so the A and B words taken at the same edge always leave on the same cycle.

Top module: `adc_out_fmt`

## Requirements
- R1: A raw pair sampled at rising edge k is shown on `dout_a_o`/`dout_b_o` from just after rising edge k+5 (LATENCY=5).
- R2: When `twos_sel_i` is 1, each bus shows the held word with its MSB inverted (two's complement). When it is 0, the word is shown unchanged (offset binary). Examples: offset 0x80 is shown as 0x00, and offset 0x00 is shown as 0x80. The coding follows `twos_sel_i` combinationally and also applies to a word that is being held.
- R3: `den_a_o` and `den_b_o` are 1 exactly when `oe_ni` is 0. The data buses are not changed by `oe_ni`.
- R4: While `sleep_i` is 1, no sample enters the pipeline and the held words do not change. The valid flags are 0 from the first edge at which sleep is sampled high.
- R5: While `pd_i` is 1, the held output words keep the last value shown before power-down, and the valid flags are 0 from the first edge at which power-down is sampled high.
- R6: After `sleep_i` falls, the next SLEEP_WAKE_CYC edges accept no sample. After `pd_i` falls, the next PD_WAKE_CYC edges accept no sample. The edge after that interval takes the first fresh sample.
- R7: After reset or a wake-up, the valid flags rise together with the first fresh word, which is LATENCY edges after it was sampled. Until then the buses keep the previously held word.
- R8: `valid_a_o` and `valid_b_o` are always equal, and both buses carry words taken at the same edge.
- R9: During reset the valid flags are 0 and both held words are bipolar zero: 0x80 when `twos_sel_i` is 0 and 0x00 when it is 1. The first sample after reset release is taken at the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_a_i | input | 8 | Channel A raw code, offset binary |
| raw_b_i | input | 8 | Channel B raw code, offset binary |
| twos_sel_i | input | 1 | 1 selects two's complement, 0 selects offset binary |
| oe_ni | input | 1 | Output drive enable, active low |
| sleep_i | input | 1 | Sleep request, stops sampling |
| pd_i | input | 1 | Power-down request, stops sampling and freezes outputs |
| dout_a_o | output | 8 | Channel A formatted word |
| dout_b_o | output | 8 | Channel B formatted word |
| den_a_o | output | 1 | Channel A bus drive enable |
| den_b_o | output | 1 | Channel B bus drive enable |
| valid_a_o | output | 1 | Channel A word is fresh |
| valid_b_o | output | 1 | Channel B word is fresh |

## Verification
The bench keeps the default latency of 5 but sets SLEEP_WAKE_CYC to 3 and PD_WAKE_CYC to 7. With these values, a complete sleep exit and a complete power-down exit each take only a handful of cycles. That makes it possible to check, cycle by cycle, the edge at which sampling resumes and the edge at which valid returns. Because the two wake counts differ, the check also confirms that each exit uses its own interval. Streams with a distinct code at every cycle show that the latency is exact and that the two channels stay aligned.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int unsigned NCH = 2;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_SLEEP = 2'd1,
    PS_DOWN  = 2'd2,
    PS_WAKE  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/adc_wake_ctrl.sv
module adc_wake_ctrl
  import adc_fmt_pkg::*;
#(
  parameter int unsigned SLEEP_WAKE_CYC = 100,
  parameter int unsigned PD_WAKE_CYC    = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic       pd_i,
  output logic       conv_en_o,
  output pwr_state_e pstate_o
);
  localparam int unsigned MAX_WAKE = (PD_WAKE_CYC > SLEEP_WAKE_CYC) ? PD_WAKE_CYC : SLEEP_WAKE_CYC;
  localparam int unsigned CNT_W    = (MAX_WAKE < 1) ? 1 : $clog2(MAX_WAKE + 1);
  localparam logic [CNT_W-1:0] SL_LD = CNT_W'(SLEEP_WAKE_CYC);
  localparam logic [CNT_W-1:0] PD_LD = CNT_W'(PD_WAKE_CYC);

  logic [CNT_W-1:0] cnt_q;

  // deepest pending wake interval wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (pd_i)            cnt_q <= PD_LD;
    else if (sleep_i)         cnt_q <= (cnt_q > SL_LD) ? cnt_q : SL_LD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    if (pd_i)               pstate_o = PS_DOWN;
    else if (sleep_i)       pstate_o = PS_SLEEP;
    else if (cnt_q != '0)   pstate_o = PS_WAKE;
    else                    pstate_o = PS_RUN;
  end

  assign conv_en_o = (pstate_o == PS_RUN);

  p_wake_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !pd_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_pd_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (cnt_q == PD_LD));
endmodule

// File: rtl/adc_lat_pipe.sv
module adc_lat_pipe #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NCH     = 2,
  parameter int unsigned LATENCY = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         conv_en_i,
  input  logic                         flush_i,
  input  logic [NCH-1:0][DATA_W-1:0]   raw_i,
  output logic                         last_vld_o,
  output logic [NCH-1:0][DATA_W-1:0]   last_dat_o
);
  logic                       vld_q [LATENCY];
  logic [NCH-1:0][DATA_W-1:0] dat_q [LATENCY];

  for (genvar g = 0; g < LATENCY; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[0] <= 1'b0;
          dat_q[0] <= '0;
        end else begin
          vld_q[0] <= conv_en_i & ~flush_i;
          dat_q[0] <= raw_i;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[g] <= 1'b0;
          dat_q[g] <= '0;
        end else begin
          vld_q[g] <= vld_q[g-1] & ~flush_i;
          dat_q[g] <= dat_q[g-1];
        end
      end
    end
  end

  assign last_vld_o = vld_q[LATENCY-1];
  assign last_dat_o = dat_q[LATENCY-1];

  p_flush_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !last_vld_o);
endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              twos_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] dout_o,
  output logic              en_o,
  output logic              valid_o
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] hold_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= MID;
      vld_q  <= 1'b0;
    end else begin
      if (load_i) hold_q <= dat_i;
      vld_q <= load_i;
    end
  end

  // offset binary -> two's complement: flip MSB
  assign dout_o  = hold_q ^ {twos_i, {(DATA_W-1){1'b0}}};
  assign en_o    = ~oe_ni;
  assign valid_o = vld_q;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (hold_q == $past(hold_q)));
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
  import adc_fmt_pkg::*;
#(
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned LATENCY        = 5,
  parameter int unsigned SLEEP_WAKE_CYC = 100,
  parameter int unsigned PD_WAKE_CYC    = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] raw_a_i,
  input  logic [DATA_W-1:0] raw_b_i,
  input  logic              twos_sel_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic              pd_i,
  output logic [DATA_W-1:0] dout_a_o,
  output logic [DATA_W-1:0] dout_b_o,
  output logic              den_a_o,
  output logic              den_b_o,
  output logic              valid_a_o,
  output logic              valid_b_o
);
  logic                       conv_en;
  pwr_state_e                 pstate;
  logic                       last_vld;
  logic [NCH-1:0][DATA_W-1:0] raw_pair;
  logic [NCH-1:0][DATA_W-1:0] last_pair;
  logic [NCH-1:0][DATA_W-1:0] dout_pair;
  logic [NCH-1:0]             den_vec;
  logic [NCH-1:0]             vld_vec;
  logic                       load;
  logic                       flush;

  assign raw_pair = {raw_b_i, raw_a_i};
  assign flush    = sleep_i | pd_i;
  assign load     = last_vld & ~flush;

  adc_wake_ctrl #(
    .SLEEP_WAKE_CYC (SLEEP_WAKE_CYC),
    .PD_WAKE_CYC    (PD_WAKE_CYC)
  ) u_wake (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep_i),
    .pd_i      (pd_i),
    .conv_en_o (conv_en),
    .pstate_o  (pstate)
  );

  adc_lat_pipe #(
    .DATA_W  (DATA_W),
    .NCH     (NCH),
    .LATENCY (LATENCY)
  ) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_en_i  (conv_en),
    .flush_i    (flush),
    .raw_i      (raw_pair),
    .last_vld_o (last_vld),
    .last_dat_o (last_pair)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    adc_code_fmt #(.DATA_W(DATA_W)) u_fmt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .dat_i   (last_pair[c]),
      .twos_i  (twos_sel_i),
      .oe_ni   (oe_ni),
      .dout_o  (dout_pair[c]),
      .en_o    (den_vec[c]),
      .valid_o (vld_vec[c])
    );
  end

  assign dout_a_o  = dout_pair[0];
  assign dout_b_o  = dout_pair[1];
  assign den_a_o   = den_vec[0];
  assign den_b_o   = den_vec[1];
  assign valid_a_o = vld_vec[0];
  assign valid_b_o = vld_vec[1];

  p_sleep_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i || pd_i) |=> (!valid_a_o && !valid_b_o));

  p_pd_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i ##1 $stable(twos_sel_i) |-> ($stable(dout_a_o) && $stable(dout_b_o)));

  p_chan_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_a_o == valid_b_o);

  p_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_a_o) |-> $past(last_vld) && ($past(pstate) == PS_RUN));
endmodule

// File: tb/adc_out_fmt_tb.sv
`timescale 1ns/1ps
module adc_out_fmt_tb;
  localparam int SLW = 3;
  localparam int PDW = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] raw_a = '0, raw_b = '0;
  logic       sel = 1'b0, oe_n = 1'b0, slp = 1'b0, pd = 1'b0;
  logic [7:0] da, db;
  logic       ena, enb, va, vb;
  int         nchk = 0, nfail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  adc_out_fmt #(.SLEEP_WAKE_CYC(SLW), .PD_WAKE_CYC(PDW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .raw_a_i(raw_a), .raw_b_i(raw_b),
    .twos_sel_i(sel), .oe_ni(oe_n), .sleep_i(slp), .pd_i(pd),
    .dout_a_o(da), .dout_b_o(db), .den_a_o(ena), .den_b_o(enb),
    .valid_a_o(va), .valid_b_o(vb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [7:0] a, input logic [7:0] b);
    raw_a = a; raw_b = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; slp = 0; pd = 0; oe_n = 0; sel = 0;
    @(negedge clk);
    chk(da == 8'h80 && db == 8'h80, "R9 reset word offset", {da, db}, 16'h8080);
    sel = 1; #0.1;
    chk(da == 8'h00 && db == 8'h00, "R9 reset word twos", {da, db}, 0);
    chk(!va && !vb, "R9 valid clear", {va, vb}, 0);
    sel = 0;
    rst_n = 1'b1;
  endtask

  task automatic t_latency();
    logic [7:0] sa [12];
    do_reset();
    for (int i = 0; i < 12; i++) begin
      sa[i] = 8'(8'h11 + i * 13);
      tick(sa[i], ~sa[i]);
      if (i >= 5) begin
        chk(da == sa[i-5], "R1 latency ch A", da, sa[i-5]);
        chk(db == ~sa[i-5], "R8 aligned ch B", db, ~sa[i-5]);
        chk(va && vb, "R7 valid after fill", {va, vb}, 2'b11);
      end else begin
        chk(!va && !vb, "R7 valid before fill", {va, vb}, 0);
        chk(da == 8'h80, "R7 held reset word", da, 8'h80);
      end
    end
  endtask

  task automatic t_format();
    for (int i = 0; i < 6; i++) tick(8'h3C, 8'h80);
    chk(da == 8'h3C && db == 8'h80, "R2 offset coding", {da, db}, 16'h3C80);
    sel = 1; #0.1;
    chk(da == 8'hBC && db == 8'h00, "R2 twos coding", {da, db}, 16'hBC00);
    for (int i = 0; i < 6; i++) tick(8'h00, 8'hFF);
    chk(da == 8'h80 && db == 8'h7F, "R2 twos full scale", {da, db}, 16'h807F);
    sel = 0; #0.1;
    chk(da == 8'h00 && db == 8'hFF, "R2 back to offset", {da, db}, 16'h00FF);
  endtask

  task automatic t_oe();
    oe_n = 1; #0.1;
    chk(!ena && !enb, "R3 disabled", {ena, enb}, 0);
    chk(da == 8'h00 && db == 8'hFF, "R3 data unaffected", {da, db}, 16'h00FF);
    oe_n = 0; #0.1;
    chk(ena && enb, "R3 enabled", {ena, enb}, 2'b11);
  endtask

  task automatic t_sleep();
    do_reset();
    for (int i = 0; i < 6; i++) tick(8'h55, 8'h66);
    chk(da == 8'h55 && va, "R4 pre-sleep word", {da, 7'b0, va}, 16'h5501);
    slp = 1;
    for (int i = 0; i < 4; i++) begin
      tick(8'hAA, 8'hBB);
      chk(da == 8'h55 && db == 8'h66, "R4 hold in sleep", {da, db}, 16'h5566);
      chk(!va && !vb, "R4 valid low in sleep", {va, vb}, 0);
    end
    slp = 0;
    for (int j = 0; j < 11; j++) begin
      tick(8'(8'h20 + j), 8'(8'h70 + j));
      if (j >= SLW + 5) begin
        chk(da == 8'(8'h20 + j - 5), "R6 sleep wake first sample", da, 8'(8'h20 + j - 5));
        chk(db == 8'(8'h70 + j - 5), "R8 sleep wake ch B", db, 8'(8'h70 + j - 5));
        chk(va && vb, "R7 valid after sleep refill", {va, vb}, 2'b11);
      end else begin
        chk(da == 8'h55 && !va, "R6 sleep wake hold", {da, 7'b0, va}, 16'h5500);
      end
    end
  endtask

  task automatic t_pd();
    do_reset();
    for (int i = 0; i < 6; i++) tick(8'h9A, 8'h12);
    pd = 1;
    for (int i = 0; i < 5; i++) begin
      tick(8'h01, 8'h02);
      chk(da == 8'h9A && db == 8'h12, "R5 freeze in power-down", {da, db}, 16'h9A12);
      chk(!va && !vb, "R5 valid low in power-down", {va, vb}, 0);
    end
    pd = 0;
    for (int j = 0; j < 15; j++) begin
      tick(8'(8'h40 + j), 8'(8'hC0 + j));
      if (j >= PDW + 5) begin
        chk(da == 8'(8'h40 + j - 5), "R6 pd wake first sample", da, 8'(8'h40 + j - 5));
        chk(db == 8'(8'hC0 + j - 5), "R8 pd wake ch B", db, 8'(8'hC0 + j - 5));
        chk(va && vb, "R7 valid after pd refill", {va, vb}, 2'b11);
      end else begin
        chk(da == 8'h9A && !va, "R6 pd wake hold", {da, 7'b0, va}, 16'h9A00);
      end
    end
  endtask

  initial begin
    t_latency();
    t_format();
    t_oe();
    t_sleep();
    t_pd();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule